// File: doc/BRIEF.md
# Reset supervisor with watchdog timer

This block decides when a microcontroller system is held in reset. It watches a digital supply-good flag from an external comparator, a chip-select line whose activity shows that software is alive, and two external reset request pins, one active high and one active low. It drives two reset outputs with the same meaning. Each is modelled as an open-drain drive enable: the active-high pin is driven high and the active-low pin is pulled low while reset is asserted. Otherwise both pins are released.

All durations are counted in clock cycles. The reset hold period and the watchdog timeout are parameters. Their defaults come from a clock-frequency parameter: about 200 ms for the hold period and 1.6 s for the watchdog. A bench can therefore use short values. One down-counter times the hold period. Power-up, external requests and watchdog expiry all reload that same counter. The watchdog counts only while the system is out of reset.

Top module: `rst_supervisor`

## Requirements
- R1: While `supply_ok` is low, both `rst_hi_drv` and `rst_lo_drv` are 1. This holds in the same cycle the flag falls, with no clock edge needed.
- R2: After `supply_ok` rises (sampled at a clock edge), both outputs stay 1 for exactly `PURST_CYC` rising clock edges and then become 0.
- R3: If `WDT_CYC` rising edges pass after release with no chip-select edge, both outputs become 1 on that edge. They stay 1 for `PURST_CYC` edges and then become 0 again.
- R4: A rising or a falling edge on `cs_n` restarts the watchdog count from zero. The restart takes effect on the third clock edge after the pin changes, because of a two-flop synchronizer followed by an edge detector.
- R5: The watchdog count is held at zero while `supply_ok` is low and while any reset hold is in progress. It restarts from zero on the edge where the outputs release.
- R6: A rising edge on `ext_rst_req` reloads the hold period on the third clock edge after the pin rises. A new edge during a hold restarts the full period. A falling edge on `ext_rst_req` does not reload it.
- R7: A falling edge on `ext_rst_req_n` reloads the hold period with the same timing. A rising edge on `ext_rst_req_n` does not reload it.
- R8: The outputs are 1 from the second clock edge after either external request becomes active (`ext_rst_req` high or `ext_rst_req_n` low). They are released at the later of two edges: the end of the hold period, or the second clock edge after the request is withdrawn.
- R9: `rst_hi_drv` and `rst_lo_drv` always carry the same value. The value 1 means drive the pin to its active level; 0 means release it.
- R10: While `rst` is high, both outputs are 1 and the hold period is reloaded on every edge. If `supply_ok` is high, the outputs release `PURST_CYC` edges after `rst` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Supply above threshold, from an external comparator |
| cs_n | input | 1 | Chip select; any edge services the watchdog |
| ext_rst_req | input | 1 | Active-high external reset request |
| ext_rst_req_n | input | 1 | Active-low external reset request |
| rst_hi_drv | output | 1 | Drive enable for the active-high reset pin |
| rst_lo_drv | output | 1 | Drive enable for the active-low reset pin |

## Verification
The hardest case to reach from the ports is the exact edge at which the watchdog fires after a chip-select edge. The kick passes through three registers before it clears the count, so an early or late clear moves the expiry by one cycle. The stimulus toggles `cs_n` in both directions and then goes quiet for a counted number of cycles, so that expiry must land on one predicted edge. The same method covers three other cases: a retriggered external request during a running hold, a request held longer than the hold period, and a brownout that lasts several watchdog periods.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    // Supervisor phase: supply down, holding reset, or running
    typedef enum logic [1:0] {
        PH_DOWN = 2'd0,
        PH_HOLD = 2'd1,
        PH_RUN  = 2'd2
    } rsv_phase_e;

    // Synchronized pin group
    typedef struct packed {
        logic cs_n;
        logic req;
        logic req_n;
    } rsv_pins_t;

    localparam int unsigned PIN_W = $bits(rsv_pins_t);

    // Idle levels of the pins, used as the synchronizer reset value
    localparam rsv_pins_t PINS_IDLE = '{cs_n: 1'b1, req: 1'b0, req_n: 1'b1};

    // Events decoded from synchronized levels and edges
    typedef struct packed {
        logic kick;   // any chip-select edge
        logic trig;   // start of an external reset request
        logic held;   // an external request is active
    } rsv_events_t;

    function automatic int unsigned cycles_for_ms(input int unsigned hz,
                                                  input int unsigned ms);
        return (hz / 1000) * ms;
    endfunction

    function automatic rsv_events_t decode_events(input rsv_pins_t lvl,
                                                  input rsv_pins_t rise,
                                                  input rsv_pins_t fall);
        rsv_events_t ev;
        ev.kick = rise.cs_n | fall.cs_n;
        ev.trig = rise.req  | fall.req_n;
        ev.held = lvl.req   | ~lvl.req_n;
        return ev;
    endfunction

endpackage

// File: rtl/rsv_sync_edge.sv
module rsv_sync_edge #(
    parameter int unsigned       WIDTH   = 3,
    parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise,
    output logic [WIDTH-1:0] fall
);

    // Per bit: two synchronizer flops, then one flop holding the previous level
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= RST_VAL[b];
                sync_q <= RST_VAL[b];
                prev_q <= RST_VAL[b];
            end else begin
                meta_q <= din[b];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign lvl[b]  = sync_q;
        assign rise[b] = sync_q & ~prev_q;
        assign fall[b] = ~sync_q & prev_q;
    end

endmodule

// File: rtl/rsv_period_timer.sv
module rsv_period_timer #(
    parameter int unsigned PERIOD = 8,
    localparam int unsigned CW    = $clog2(PERIOD + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    output logic          busy,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] FULL = CW'(PERIOD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= FULL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign cnt  = cnt_q;

endmodule

// File: rtl/rsv_watchdog.sv
module rsv_watchdog #(
    parameter int unsigned LIMIT = 20,
    localparam int unsigned CW   = $clog2(LIMIT)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic          kick,
    output logic          fire,
    output logic [CW-1:0] cnt
);

    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    assign fire = run && !kick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || kick || fire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned PURST_CYC = rsv_pkg::cycles_for_ms(CLK_HZ, 200),
    parameter int unsigned WDT_CYC   = rsv_pkg::cycles_for_ms(CLK_HZ, 1600)
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic cs_n,
    input  logic ext_rst_req,
    input  logic ext_rst_req_n,
    output logic rst_hi_drv,
    output logic rst_lo_drv
);
    import rsv_pkg::*;

    localparam int unsigned TMR_W = $clog2(PURST_CYC + 1);
    localparam int unsigned WDT_W = $clog2(WDT_CYC);

    rsv_pins_t   pins_in, pins_lvl, pins_rise, pins_fall;
    rsv_events_t ev;
    rsv_phase_e  phase;

    logic             tmr_busy;
    logic [TMR_W-1:0] tmr_cnt;
    logic             tmr_load;
    logic             wdt_fire;
    logic [WDT_W-1:0] wdt_cnt;
    logic             cs_kick, ext_trig, ext_held;

    assign pins_in = '{cs_n: cs_n, req: ext_rst_req, req_n: ext_rst_req_n};

    rsv_sync_edge #(
        .WIDTH   (PIN_W),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_in),
        .lvl  (pins_lvl),
        .rise (pins_rise),
        .fall (pins_fall)
    );

    assign ev       = decode_events(pins_lvl, pins_rise, pins_fall);
    assign cs_kick  = ev.kick;
    assign ext_trig = ev.trig;
    assign ext_held = ev.held;

    // Every reset source reloads the same hold counter
    assign tmr_load = !supply_ok || ext_trig || wdt_fire;

    rsv_period_timer #(
        .PERIOD (PURST_CYC)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tmr_load),
        .busy (tmr_busy),
        .cnt  (tmr_cnt)
    );

    // The supply flag acts without a clock edge, so a brownout asserts at once
    always_comb begin
        if (!supply_ok) begin
            phase = PH_DOWN;
        end else if (tmr_busy || ext_held) begin
            phase = PH_HOLD;
        end else begin
            phase = PH_RUN;
        end
    end

    rsv_watchdog #(
        .LIMIT (WDT_CYC)
    ) u_wdt (
        .clk  (clk),
        .rst  (rst),
        .run  (phase == PH_RUN),
        .kick (cs_kick),
        .fire (wdt_fire),
        .cnt  (wdt_cnt)
    );

    assign rst_hi_drv = (phase != PH_RUN);
    assign rst_lo_drv = (phase != PH_RUN);

endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
    parameter int unsigned PURST_CYC = 8,
    parameter int unsigned WDT_CYC   = 20,
    localparam int unsigned TMR_W    = $clog2(PURST_CYC + 1),
    localparam int unsigned WDT_W    = $clog2(WDT_CYC)
) (
    input logic             clk,
    input logic             rst,
    input logic             supply_ok,
    input logic             rst_hi_drv,
    input logic             rst_lo_drv,
    input logic             cs_kick,
    input logic             ext_trig,
    input logic             ext_held,
    input logic             wdt_fire,
    input logic [WDT_W-1:0] wdt_cnt,
    input logic [TMR_W-1:0] tmr_cnt
);

    localparam logic [TMR_W-1:0] FULL = TMR_W'(PURST_CYC);

    p_supply_low_r1: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |-> (rst_hi_drv && rst_lo_drv));

    p_rise_loaded_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_ok) |-> (tmr_cnt == FULL && rst_hi_drv));

    p_fire_holds_r3: assert property (@(posedge clk) disable iff (rst)
        wdt_fire |=> (tmr_cnt == FULL && rst_lo_drv && wdt_cnt == '0));

    p_kick_clears_r4: assert property (@(posedge clk) disable iff (rst)
        cs_kick |=> (wdt_cnt == '0));

    p_down_clears_r5: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> (wdt_cnt == '0));

    // Covers both request polarities (R7 as well)
    p_trig_reloads_r6: assert property (@(posedge clk) disable iff (rst)
        ext_trig |=> (tmr_cnt == FULL));

    p_held_asserts_r8: assert property (@(posedge clk) disable iff (rst)
        ext_held |-> (rst_hi_drv && rst_lo_drv));

    p_outputs_agree_r9: assert property (@(posedge clk) disable iff (rst)
        rst_hi_drv == rst_lo_drv);

endmodule

bind rst_supervisor rsv_checker #(
    .PURST_CYC (PURST_CYC),
    .WDT_CYC   (WDT_CYC)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .rst_hi_drv (rst_hi_drv),
    .rst_lo_drv (rst_lo_drv),
    .cs_kick    (cs_kick),
    .ext_trig   (ext_trig),
    .ext_held   (ext_held),
    .wdt_fire   (wdt_fire),
    .wdt_cnt    (wdt_cnt),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/rst_supervisor_test.sv
module rst_supervisor_test;

    localparam int unsigned P = 8;
    localparam int unsigned W = 20;

    logic clk = 1'b0;
    logic rst, supply_ok, cs_n, ext_rst_req, ext_rst_req_n;
    logic rst_hi_drv, rst_lo_drv;

    int vectors = 0;
    int miscompares = 0;

    always #10 clk = ~clk;   // 50 MHz

    rst_supervisor #(
        .CLK_HZ    (1000),
        .PURST_CYC (P),
        .WDT_CYC   (W)
    ) uut (
        .clk           (clk),
        .rst           (rst),
        .supply_ok     (supply_ok),
        .cs_n          (cs_n),
        .ext_rst_req   (ext_rst_req),
        .ext_rst_req_n (ext_rst_req_n),
        .rst_hi_drv    (rst_hi_drv),
        .rst_lo_drv    (rst_lo_drv)
    );

    // Entry: [16:13] {supply_ok, cs_n, ext_rst_req, ext_rst_req_n},
    //        [12:5] edges to wait, [4:1] requirement number, [0] expected
    localparam int NV = 29;
    localparam logic [16:0] VECS [NV] = '{
        {4'b0101, 8'd3,  4'd1, 1'b1},   // R1 supply low
        {4'b1101, 8'd7,  4'd2, 1'b1},   // R2 one edge before release
        {4'b1101, 8'd1,  4'd2, 1'b0},   // R2 released after P edges
        {4'b1101, 8'd19, 4'd3, 1'b0},   // R3 one edge before expiry
        {4'b1101, 8'd1,  4'd3, 1'b1},   // R3 expiry
        {4'b1101, 8'd7,  4'd3, 1'b1},   // R3 hold after expiry
        {4'b1101, 8'd1,  4'd5, 1'b0},   // R5 release, count from zero
        {4'b1001, 8'd12, 4'd4, 1'b0},   // R4 falling chip-select kick
        {4'b1101, 8'd12, 4'd4, 1'b0},   // R4 rising chip-select kick
        {4'b1101, 8'd10, 4'd4, 1'b0},   // R4 count restarted at the kick
        {4'b1101, 8'd1,  4'd4, 1'b1},   // R4 expiry edge after the last kick
        {4'b1101, 8'd7,  4'd3, 1'b1},   // R3
        {4'b1101, 8'd1,  4'd3, 1'b0},   // R3
        {4'b1111, 8'd1,  4'd6, 1'b0},   // R6 request still in synchronizer
        {4'b1101, 8'd1,  4'd8, 1'b1},   // R8 synchronized level asserts
        {4'b1101, 8'd8,  4'd6, 1'b1},   // R6 hold period running
        {4'b1101, 8'd1,  4'd6, 1'b0},   // R6 released, falling edge no reload
        {4'b1100, 8'd14, 4'd7, 1'b1},   // R7 low request held past period
        {4'b1101, 8'd1,  4'd8, 1'b1},   // R8 still held by synchronizer
        {4'b1101, 8'd1,  4'd7, 1'b0},   // R7 rising edge does not reload
        {4'b1101, 8'd19, 4'd5, 1'b0},   // R5 count restarted at release
        {4'b1101, 8'd1,  4'd3, 1'b1},   // R3
        {4'b1101, 8'd7,  4'd3, 1'b1},   // R3
        {4'b1101, 8'd1,  4'd3, 1'b0},   // R3
        {4'b1111, 8'd1,  4'd6, 1'b0},   // R6 first request
        {4'b1101, 8'd5,  4'd6, 1'b1},   // R6
        {4'b1111, 8'd1,  4'd6, 1'b1},   // R6 retrigger during hold
        {4'b1101, 8'd9,  4'd6, 1'b1},   // R6 full period restarted
        {4'b1101, 8'd1,  4'd6, 1'b0}    // R6 released
    };

    task automatic check(input logic exp, input int req, input string what);
        vectors++;
        if (rst_hi_drv !== exp || rst_lo_drv !== exp) begin
            miscompares++;
            $display("FAIL R%0d %s: hi_drv=%b lo_drv=%b expected %b",
                     req, what, rst_hi_drv, rst_lo_drv, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; supply_ok = 1'b0; cs_n = 1'b1;
        ext_rst_req = 1'b0; ext_rst_req_n = 1'b1;
        edges(3);
        check(1'b1, 10, "R10 outputs during reset");
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            {supply_ok, cs_n, ext_rst_req, ext_rst_req_n} = VECS[i][16:13];
            edges(int'(VECS[i][12:5]));
            check(VECS[i][0], int'(VECS[i][4:1]), $sformatf("vector %0d", i));
        end

        // R1: a brownout asserts without waiting for a clock edge
        supply_ok = 1'b0;
        #1;
        check(1'b1, 1, "R1 immediate brownout");
        edges(3 * W);
        check(1'b1, 5, "R5 long brownout, no expiry");
        supply_ok = 1'b1;
        edges(P - 1);
        check(1'b1, 2, "R2 hold after supply returns");
        edges(1);
        check(1'b0, 2, "R2 release");
        edges(W - 1);
        check(1'b0, 5, "R5 watchdog was held clear");
        edges(1);
        check(1'b1, 3, "R3 expiry after brownout");
        edges(P);
        check(1'b0, 3, "R3 release after expiry");

        // R10: synchronous reset in the middle of operation
        edges(5);
        rst = 1'b1;
        edges(2);
        check(1'b1, 10, "R10 reset asserted mid-run");
        rst = 1'b0;
        edges(P - 1);
        check(1'b1, 10, "R10 hold after reset");
        edges(1);
        check(1'b0, 10, "R10 release after reset");

        // R4: regular kicks in both directions keep the system out of reset
        for (int k = 0; k < 10; k++) begin
            cs_n = ~cs_n;
            edges(8);
            check(1'b0, 4, "R4 serviced watchdog");
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule